// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over running software with an 8-bit up counter that advances on a prescaled tick. Software restarts the count by writing a key value to a clear port. The write is honoured only while the count sits inside a programmable clear window, which closes for the first quarter, half or three quarters of the count range. If the counter wraps past its top value, or a key write arrives while the window is still closed, the block raises a malfunction event.

A control bit picks the form of that event. It is either a reset request that holds until the next system reset, or a one-cycle non-maskable interrupt pulse. In interrupt form the counter keeps running and wraps. A clear written while the window is closed also sets a sticky error flag.

The tick comes either from the main clock, which is always stepping, or from a slow-clock enable pulse, depending on a mode input. A low-power indication freezes the count and the prescaler in place. Counting resumes from the held value when that indication drops.

Top module: `wdt_window_top`

## Requirements
- R1: With fast mode selected (slow_mode=0), the tick period is 2^(FAST_LOG_BASE + LOG_STEP*k) clock cycles, where k is the overflow-time code. With the defaults this is 2^10, 2^12, 2^14 or 2^16. The first overflow event comes 256 ticks after the enabling write.
- R2: With slow mode selected (slow_mode=1), the tick period is 2^(SLOW_LOG_BASE + LOG_STEP*k) cycles in which slow_tick is high. With the defaults this is 8, 32, 128 or 512 slow ticks.
- R3: In interrupt form (output-type bit 0), each event gives nmi_pulse high for exactly one cycle. The counter wraps to zero and keeps counting, so the next overflow comes 256 ticks later.
- R4: In reset form (output-type bit 1), an event sets rst_req. rst_req then stays high, whatever is written to the control register, until rst_n is asserted. nmi_pulse stays low.
- R5: A clear_wr write of 0x4E while the window is open sets the counter and the prescaler to zero. A write of any other value is ignored.
- R6: The window code sets where a key write is accepted. Code 00 accepts it at any count. Codes 01, 10 and 11 accept it only when the count is at least 0x40, 0x80 or 0xC0, respectively.
- R7: A key write while the window is closed raises an event of the selected form and sets err_flag. err_flag stays set until rst_n. The counter is not cleared by that write.
- R8: While freeze is high, the counter and the prescaler hold their values. Counting resumes from the held value when freeze drops.
- R9: While the enable bit is 0, the counter and the prescaler are held at zero, no event is raised, and key writes are ignored.
- R10: A control write with cfg_wr loads cfg_data. The field positions are: bit 0 enable, bits 2:1 overflow-time code, bits 4:3 window code, bit 5 output type. The register resets to all zeros.
- R11: After reset, rst_req, nmi_pulse and err_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_data | input | 6 | Control register write data |
| clr_wr | input | 1 | Clear register write strobe |
| clr_data | input | 8 | Clear register write data (key 0x4E) |
| slow_mode | input | 1 | 1 selects the slow tick source |
| slow_tick | input | 1 | Slow-clock enable pulse, synchronous to clk |
| freeze | input | 1 | Low-power indication; pauses counting |
| rst_req | output | 1 | Level reset request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| err_flag | output | 1 | Sticky flag for a clear outside the window |

## Verification
Some properties are checked on every cycle:
- the reset request and the error flag never drop once set;
- a disabled watchdog keeps its count at zero and stays silent;
- a frozen count does not move;
- the count never advances by more than one step per cycle.

Other behaviour only the bench scenarios can show:
- the exact overflow timing for each divider code in both clock modes;
- where each window opens, including the 0xBF/0xC0 boundary;
- that a rejected key leaves the count alone;
- the extra delay that a freeze adds.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned CTRL_W = 6;
   localparam int unsigned KEY_W  = 8;
   localparam logic [KEY_W-1:0] CLR_KEY = 8'h4E;

   typedef struct packed {
      logic       out_rst;   // bit 5: 1 = reset request, 0 = interrupt
      logic [1:0] win;       // bits 4:3: clear window code
      logic [1:0] otime;     // bits 2:1: overflow time code
      logic       en;        // bit 0: enable
   } wdt_ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned FAST_LOG_BASE = 10,
   parameter int unsigned SLOW_LOG_BASE = 3,
   parameter int unsigned LOG_STEP      = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       zero,
   input  logic       slow_mode,
   input  logic       slow_tick,
   input  logic [1:0] otime,
   output logic       tick
);
   localparam int unsigned MAX_BASE = (FAST_LOG_BASE > SLOW_LOG_BASE) ? FAST_LOG_BASE : SLOW_LOG_BASE;
   localparam int unsigned PRE_W    = MAX_BASE + 3 * LOG_STEP;
   localparam int unsigned N_CODES  = 4;

   if (FAST_LOG_BASE < 1 || SLOW_LOG_BASE < 1) begin : g_bad_base
      $error("wdt_prescaler: divider bases must be at least 1");
   end
   if (PRE_W > 32) begin : g_bad_width
      $error("wdt_prescaler: prescaler wider than 32 bits");
   end

   logic [PRE_W-1:0] lim_fast [N_CODES];
   logic [PRE_W-1:0] lim_slow [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_lim
      assign lim_fast[g] = PRE_W'((64'd1 << (FAST_LOG_BASE + g * LOG_STEP)) - 64'd1);
      assign lim_slow[g] = PRE_W'((64'd1 << (SLOW_LOG_BASE + g * LOG_STEP)) - 64'd1);
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;
   logic             step;

   always_comb begin
      lim  = slow_mode ? lim_slow[otime] : lim_fast[otime];
      step = slow_mode ? slow_tick : 1'b1;
      tick = run && step && (pre_q >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (zero) begin
         pre_q <= '0;
      end else if (run && step) begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zero,
   input  logic             key_wr,
   input  logic             tick,
   input  logic [1:0]       win,
   output logic [CNT_W-1:0] cnt,
   output logic             clr_ok,
   output logic             bad_clr,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] TOP = '1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdt_counter: counter needs at least 2 bits");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             open;

   always_comb begin
      open    = (cnt_q[CNT_W-1 -: 2] >= win);
      clr_ok  = key_wr && open;
      bad_clr = key_wr && !open;
      ovf     = tick && (cnt_q == TOP) && !clr_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (zero || clr_ok) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/wdt_response.sv
module wdt_response (
   input  logic clk,
   input  logic rst_n,
   input  logic out_rst,
   input  logic ovf,
   input  logic bad_clr,
   output logic rst_req,
   output logic nmi_pulse,
   output logic err_flag
);
   logic evt;
   assign evt = ovf || bad_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req   <= 1'b0;
         nmi_pulse <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         nmi_pulse <= evt && !out_rst;
         if (evt && out_rst) rst_req  <= 1'b1;
         if (bad_clr)        err_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W         = 8,
   parameter int unsigned FAST_LOG_BASE = 10,
   parameter int unsigned SLOW_LOG_BASE = 3,
   parameter int unsigned LOG_STEP      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CTRL_W-1:0] cfg_data,
   input  logic              clr_wr,
   input  logic [KEY_W-1:0]  clr_data,
   input  logic              slow_mode,
   input  logic              slow_tick,
   input  logic              freeze,
   output logic              rst_req,
   output logic              nmi_pulse,
   output logic              err_flag
);
   wdt_ctrl_t        ctrl_q;
   logic             key_wr;
   logic             tick;
   logic             clr_ok;
   logic             bad_clr;
   logic             ovf;
   logic [CNT_W-1:0] cnt_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (cfg_wr) ctrl_q <= wdt_ctrl_t'(cfg_data);
   end

   assign key_wr = ctrl_q.en && clr_wr && (clr_data == CLR_KEY);

   wdt_prescaler #(
      .FAST_LOG_BASE (FAST_LOG_BASE),
      .SLOW_LOG_BASE (SLOW_LOG_BASE),
      .LOG_STEP      (LOG_STEP)
   ) pre_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_q.en && !freeze),
      .zero      (!ctrl_q.en || clr_ok),
      .slow_mode (slow_mode),
      .slow_tick (slow_tick),
      .otime     (ctrl_q.otime),
      .tick      (tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .zero    (!ctrl_q.en),
      .key_wr  (key_wr),
      .tick    (tick),
      .win     (ctrl_q.win),
      .cnt     (cnt_w),
      .clr_ok  (clr_ok),
      .bad_clr (bad_clr),
      .ovf     (ovf)
   );

   wdt_response rsp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_rst   (ctrl_q.out_rst),
      .ovf       (ovf),
      .bad_clr   (bad_clr),
      .rst_req   (rst_req),
      .nmi_pulse (nmi_pulse),
      .err_flag  (err_flag)
   );
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             freeze,
   input logic             clr_wr,
   input logic             cfg_wr,
   input logic [CNT_W-1:0] cnt,
   input logic             rst_req,
   input logic             nmi_pulse,
   input logic             err_flag
);
   // R4
   rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag);
   // R9
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !nmi_pulse);
   // R9
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (cnt == '0));
   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && freeze && !clr_wr && !cfg_wr) |=> $stable(cnt));
   // R1
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr_wr && !cfg_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (ctrl_q.en),
   .freeze    (freeze),
   .clr_wr    (clr_wr),
   .cfg_wr    (cfg_wr),
   .cnt       (cnt_w),
   .rst_req   (rst_req),
   .nmi_pulse (nmi_pulse),
   .err_flag  (err_flag)
);

// File: tb/wdt_window_top_tb_top.sv
module wdt_window_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [5:0] cfg_data = '0;
   logic       clr_wr = 1'b0;
   logic [7:0] clr_data = '0;
   logic       slow_mode = 1'b0;
   logic       slow_tick = 1'b0;
   logic       freeze = 1'b0;
   logic       rst_req, nmi_pulse, err_flag;
   int         checks = 0;
   int         errors = 0;
   int         n;

   // Bench dividers: fast 4,8,16,32 cycles; slow 2,4,8,16 slow ticks
   wdt_window_top #(.CNT_W(8), .FAST_LOG_BASE(2), .SLOW_LOG_BASE(1), .LOG_STEP(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .clr_wr(clr_wr), .clr_data(clr_data), .slow_mode(slow_mode),
      .slow_tick(slow_tick), .freeze(freeze),
      .rst_req(rst_req), .nmi_pulse(nmi_pulse), .err_flag(err_flag));

   always #2 clk = ~clk;

   // vector table: slow mode, overflow code, expected cycles to first event
   localparam int NV = 5;
   localparam int V_SLOW [NV] = '{0, 0, 0, 1, 1};
   localparam int V_OT   [NV] = '{0, 1, 3, 0, 2};
   localparam int V_EXP  [NV] = '{1024, 2048, 8192, 512, 2048};

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int k);
      repeat (k) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr_cfg(input logic [5:0] v);
      cfg_data = v; cfg_wr = 1'b1;
      step(1);
      cfg_wr = 1'b0;
   endtask

   task automatic wr_clr(input logic [7:0] v);
      clr_data = v; clr_wr = 1'b1;
      step(1);
      clr_wr = 1'b0;
   endtask

   task automatic wait_evt(input int mx, output int cnt_o);
      cnt_o = mx + 1;
      for (int i = 1; i <= mx; i++) begin
         step(1);
         if (nmi_pulse || rst_req) begin
            cnt_o = i;
            break;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(2);
      // R11: reset state
      chk(!rst_req && !nmi_pulse && !err_flag, "R11 outputs low in reset",
          {rst_req, nmi_pulse, err_flag}, 0);
      rst_n = 1'b1;
      step(1);

      // R1 R2 R3 R10: divider table in interrupt form
      for (int v = 0; v < NV; v++) begin
         slow_mode = V_SLOW[v][0];
         slow_tick = V_SLOW[v][0];
         wr_cfg(6'((V_OT[v] << 1) | 1));
         wait_evt(V_EXP[v] + 10, n);
         chk(n == V_EXP[v], V_SLOW[v] != 0 ? "R2 slow overflow time" : "R1 fast overflow time", n, V_EXP[v]);
         step(1);
         chk(!nmi_pulse, "R3 pulse lasts one cycle", nmi_pulse, 0);
         wait_evt(V_EXP[v] + 10, n);
         chk(n == V_EXP[v] - 1, "R3 counting continues after overflow", n, V_EXP[v] - 1);
         wr_cfg(6'h00);
         slow_mode = 1'b0; slow_tick = 1'b0;
      end

      // R5 R6: window 01, valid clear at count 0x4A
      wr_cfg(6'h09);
      step(299);
      wr_clr(8'h4E);
      wait_evt(1100, n);
      chk(n == 1024, "R5 valid clear restarts count", n, 1024);
      chk(!err_flag, "R6 clear inside window 01 no error", err_flag, 0);
      wr_cfg(6'h00);

      // R5: wrong key is ignored
      wr_cfg(6'h01);
      step(499);
      wr_clr(8'h12);
      wait_evt(1100, n);
      chk(n == 524, "R5 wrong key ignored", n, 524);
      chk(!err_flag, "R5 wrong key no error", err_flag, 0);
      wr_cfg(6'h00);

      // R7 R6: window 11, key at count 0xBF is rejected
      wr_cfg(6'h19);
      step(767);
      wr_clr(8'h4E);
      chk(nmi_pulse && err_flag, "R7 early clear raises event", {nmi_pulse, err_flag}, 3);
      wait_evt(1100, n);
      chk(n == 256, "R7 rejected clear leaves count", n, 256);
      wr_cfg(6'h00);
      step(3);
      chk(err_flag, "R7 error flag sticky", err_flag, 1);
      do_reset();
      chk(!err_flag, "R7 error cleared by reset", err_flag, 0);

      // R6: window 11, key at count 0xC0 accepted
      wr_cfg(6'h19);
      step(768);
      wr_clr(8'h4E);
      chk(!err_flag && !nmi_pulse, "R6 clear at 0xC0 accepted", {nmi_pulse, err_flag}, 0);
      wait_evt(1100, n);
      chk(n == 1024, "R6 window 11 clear restarts", n, 1024);
      wr_cfg(6'h00);

      // R6: window 00, clear at count 1 accepted
      wr_cfg(6'h01);
      step(4);
      wr_clr(8'h4E);
      wait_evt(1100, n);
      chk(n == 1024 && !err_flag, "R6 window 00 any count", n, 1024);
      wr_cfg(6'h00);

      // R8: freeze adds its length to the overflow time
      wr_cfg(6'h01);
      step(99);
      freeze = 1'b1;
      step(50);
      freeze = 1'b0;
      wait_evt(1100, n);
      chk(n == 925, "R8 freeze pauses count", n, 925);
      wr_cfg(6'h00);

      // R9: disabled block stays silent and ignores key
      wr_cfg(6'h01);
      step(500);
      wr_cfg(6'h00);
      wr_clr(8'h4E);
      chk(!err_flag, "R9 key ignored when disabled", err_flag, 0);
      wait_evt(3000, n);
      chk(n == 3001, "R9 no event when disabled", n, 3001);
      wr_cfg(6'h01);
      wait_evt(1100, n);
      chk(n == 1024, "R9 counter held at zero", n, 1024);
      wr_cfg(6'h00);

      // R4: reset form holds until rst_n
      wr_cfg(6'h21);
      wait_evt(1100, n);
      chk(n == 1024 && rst_req && !nmi_pulse, "R4 reset request on overflow", n, 1024);
      step(300);
      wr_cfg(6'h00);
      step(2);
      chk(rst_req && !nmi_pulse, "R4 reset request held", rst_req, 1);
      do_reset();
      chk(!rst_req, "R4 cleared by system reset", rst_req, 0);
      wait_evt(1200, n);
      chk(n == 1201, "R10 control resets disabled", n, 1201);

      // R7 R4: rejected clear in reset form
      wr_cfg(6'h29);
      step(9);
      wr_clr(8'h4E);
      chk(rst_req && err_flag && !nmi_pulse, "R7 early clear in reset form",
          {rst_req, err_flag, nmi_pulse}, 6);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule